// File: doc/BRIEF.md
# Three-Wire Synthesizer Register Loader

This block is the programming port of a dual frequency synthesizer. A host writes it over three slow pins: a serial clock, a serial data line and a latch strobe. While the strobe is low, every rising edge of the serial clock moves one data bit into a 22-bit shift register. The most significant bit arrives first and the least significant bit arrives last.

A rising edge on the strobe commits the word. The two bits that arrived last form a destination code. The twenty bits that arrived before them are copied into one of four holding registers: a reference divider setting or a main (N) divider setting, for either the RF loop or the IF loop. The holding registers drive the divider logic directly. Each one carries a flag that rises on its first write after reset.

All three pins are asynchronous to the system clock. Each pin passes through its own two-flop synchronizer, and edges are found in the system clock domain. The host's serial clock must therefore stay high, and stay low, for several system clock periods.

Top module: `synth_loader`

## Requirements
- R1: After a synchronous reset all four divider outputs read zero, every bit of `loaded` is 0, and the shift register is empty (all zero).
- R2: Bits enter MSB first. The first bit of a 22-bit transfer lands in word bit 21 and the last lands in word bit 0.
- R3: On a strobe rising edge, word bits [21:2] are copied to the register that word bits [1:0] select: 00 RF reference, 01 RF N, 10 IF reference, 11 IF N.
- R4: A commit leaves the three registers that were not addressed unchanged.
- R5: Serial clock edges without a strobe rising edge never change any divider output or `loaded`.
- R6: When more than 22 bits are shifted before a commit, only the last 22 bits count. Older bits are pushed out.
- R7: `loaded[k]` (bit 0 RF reference, 1 RF N, 2 IF reference, 3 IF N) goes to 1 on the first commit to register k and stays at 1 until reset.
- R8: While the strobe is high, serial clock edges do not shift. Each strobe rising edge commits exactly once, using the shift register as it stood when the strobe rose.
- R9: A commit does not clear the shift register. A short transfer of fewer than 22 bits is combined with the bits left over from earlier transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock pin, asynchronous |
| ser_dat | input | 1 | Serial data pin, asynchronous |
| ser_le | input | 1 | Latch strobe pin, asynchronous, commits on rising edge |
| rf_ref_div | output | 20 | RF reference divider setting |
| rf_n_div | output | 20 | RF N divider setting |
| if_ref_div | output | 20 | IF reference divider setting |
| if_n_div | output | 20 | IF N divider setting |
| loaded | output | 4 | Per-register written-since-reset flags |

## Verification
The bench targets the following corner cases. Each one is listed with the way a wrong design would show it.

- **Bit order:** a design that reversed the order would put the destination code at the MSB end and write the wrong register.
- **Overlong transfer (26 bits):** a design that stopped after 22 bits would keep the oldest bits instead of the newest.
- **Clocks with the strobe held high:** a design that kept shifting there would commit a corrupted word on the next strobe.
- **Short transfer:** a design that cleared the shift register on commit would write zeros where leftover bits belong.
- **Commit without a strobe, and a fresh reset:** these expose a stuck or early `loaded` flag, or a write that needs no strobe.

// File: rtl/synth_loader_pkg.sv
package synth_loader_pkg;
  localparam int unsigned WORD_BITS = 22;
  localparam int unsigned DEST_BITS = 2;

  typedef enum logic [DEST_BITS-1:0] {
    DEST_RF_REF = 2'd0,
    DEST_RF_N   = 2'd1,
    DEST_IF_REF = 2'd2,
    DEST_IF_N   = 2'd3
  } dest_e;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int unsigned N      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pin,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  logic [N-1:0] chain [STAGES+1];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s <= STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= pin;
      for (int s = 1; s <= STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign lvl  = chain[STAGES-1];
  assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/ser_shift.sv
module ser_shift #(
  parameter int unsigned W = 22
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic         hold,
  input  logic         din,
  output logic [W-1:0] word
);
  always_ff @(posedge clk) begin
    if (rst)               word <= '0;
    else if (step && !hold) word <= {word[W-2:0], din};
  end

  assert_hold_no_shift_R8: assert property (@(posedge clk) disable iff (rst)
    hold |=> $stable(word));
  assert_newest_in_lsb_R2: assert property (@(posedge clk) disable iff (rst)
    (step && !hold) |=> (word[0] == $past(din)));
  assert_oldest_pushed_out_R6: assert property (@(posedge clk) disable iff (rst)
    (step && !hold) |=> (word[W-1:1] == $past(word[W-2:0])));
endmodule

// File: rtl/reg_bank.sv
module reg_bank #(
  parameter int unsigned AW = 2,
  parameter int unsigned PW = 20,
  localparam int unsigned NREG = 1 << AW
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   commit,
  input  logic [PW+AW-1:0]       word,
  output logic [NREG-1:0][PW-1:0] q,
  output logic [NREG-1:0]        valid
);
  logic [AW-1:0] dest;
  logic [PW-1:0] payload;

  assign dest    = word[AW-1:0];
  assign payload = word[PW+AW-1:AW];

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        q[k]     <= '0;
        valid[k] <= 1'b0;
      end else if (commit && (dest == AW'(k))) begin
        q[k]     <= payload;
        valid[k] <= 1'b1;
      end
    end

    assert_addressed_written_R3: assert property (@(posedge clk) disable iff (rst)
      (commit && dest == AW'(k)) |=> (q[k] == $past(payload)));
    assert_others_hold_R4: assert property (@(posedge clk) disable iff (rst)
      (commit && dest != AW'(k)) |=> $stable(q[k]));
    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (rst)
      valid[k] |=> valid[k]);
  end

  assert_no_commit_no_change_R5: assert property (@(posedge clk) disable iff (rst)
    !commit |=> ($stable(q) && $stable(valid)));
endmodule

// File: rtl/synth_loader.sv
module synth_loader
  import synth_loader_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned PAY_BITS = WORD_BITS - DEST_BITS,
  localparam int unsigned NREG     = 1 << DEST_BITS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ser_clk,
  input  logic                ser_dat,
  input  logic                ser_le,
  output logic [PAY_BITS-1:0] rf_ref_div,
  output logic [PAY_BITS-1:0] rf_n_div,
  output logic [PAY_BITS-1:0] if_ref_div,
  output logic [PAY_BITS-1:0] if_n_div,
  output logic [NREG-1:0]     loaded
);
  logic [2:0] pin_lvl, pin_rise;
  logic [WORD_BITS-1:0] sr_word;
  logic [NREG-1:0][PAY_BITS-1:0] bank_q;
  logic unused_sync;

  pin_sync #(.N(3), .STAGES(SYNC_STAGES)) sync_i (
    .clk (clk),
    .rst (rst),
    .pin ({ser_le, ser_dat, ser_clk}),
    .lvl (pin_lvl),
    .rise(pin_rise)
  );

  assign unused_sync = ^{pin_lvl[0], pin_rise[1]};

  ser_shift #(.W(WORD_BITS)) shift_i (
    .clk (clk),
    .rst (rst),
    .step(pin_rise[0]),
    .hold(pin_lvl[2]),
    .din (pin_lvl[1]),
    .word(sr_word)
  );

  reg_bank #(.AW(DEST_BITS), .PW(PAY_BITS)) bank_i (
    .clk   (clk),
    .rst   (rst),
    .commit(pin_rise[2]),
    .word  (sr_word),
    .q     (bank_q),
    .valid (loaded)
  );

  assign rf_ref_div = bank_q[DEST_RF_REF];
  assign rf_n_div   = bank_q[DEST_RF_N];
  assign if_ref_div = bank_q[DEST_IF_REF];
  assign if_n_div   = bank_q[DEST_IF_N];

  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> (loaded == '0 && sr_word == '0));
endmodule

// File: tb/synth_loader_tb_top.sv
module synth_loader_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_le = 1'b0;
  logic [19:0] rf_ref_div, rf_n_div, if_ref_div, if_n_div;
  logic [3:0] loaded;

  int total = 0, bad = 0;
  bit done = 0;
  logic [21:0] m_sr;
  logic [19:0] m_reg [4];
  logic [3:0] m_val;
  logic m_le;

  always #4 clk = ~clk;

  synth_loader dut_i (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_le(ser_le),
    .rf_ref_div(rf_ref_div), .rf_n_div(rf_n_div), .if_ref_div(if_ref_div),
    .if_n_div(if_n_div), .loaded(loaded)
  );

  localparam logic [21:0] VEC [8] = '{
    {20'hABCDE, 2'b00}, {20'h12345, 2'b01}, {20'hFFFFF, 2'b10}, {20'h00001, 2'b11},
    {20'h80000, 2'b01}, {20'h5A5A5, 2'b00}, {20'h0F0F0, 2'b11}, {20'h3C3C3, 2'b10}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    repeat (2) @(negedge clk);
    chk(req, 32'(rf_ref_div), 32'(m_reg[0]));
    chk(req, 32'(rf_n_div),   32'(m_reg[1]));
    chk(req, 32'(if_ref_div), 32'(m_reg[2]));
    chk(req, 32'(if_n_div),   32'(m_reg[3]));
    chk(req, 32'(loaded),     32'(m_val));
  endtask

  task automatic model_reset();
    m_sr = '0; m_val = '0; m_le = 1'b0;
    for (int k = 0; k < 4; k++) m_reg[k] = '0;
  endtask

  task automatic send_bit(logic b);
    @(negedge clk); ser_dat = b;
    repeat (3) @(negedge clk); ser_clk = 1'b1;
    repeat (4) @(negedge clk); ser_clk = 1'b0;
    repeat (3) @(negedge clk);
    if (!m_le) m_sr = {m_sr[20:0], b};
  endtask

  task automatic send_word(logic [31:0] w, int n);
    for (int i = n - 1; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic le_set(logic v);
    repeat (3) @(negedge clk);
    ser_le = v;
    if (v && !m_le) begin
      m_reg[m_sr[1:0]] = m_sr[21:2];
      m_val[m_sr[1:0]] = 1'b1;
    end
    m_le = v;
    repeat (6) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; ser_clk = 0; ser_dat = 0; ser_le = 0;
    repeat (5) @(negedge clk); rst = 1'b0;
    model_reset();
  endtask

  initial begin
    model_reset();
    do_reset();
    check_all("R1 reset state");

    // R7: first commit sets only its own flag (IF reference, code 10)
    send_word({10'd0, 20'h00777, 2'b10}, 22);
    le_set(1); le_set(0);
    check_all("R7 first write flag");
    chk("R7 only bit2", 32'(loaded), 32'h4);

    // R2 R3 R4 R7: table walk
    for (int v = 0; v < 8; v++) begin
      send_word(32'(VEC[v]), 22);
      le_set(1); le_set(0);
      check_all("R3 R4 table word");
    end
    chk("R2 R3 msb-first payload", 32'(if_ref_div), 32'h3C3C3);

    // R5: full word shifted, no strobe
    send_word({10'd0, 20'h11111, 2'b00}, 22);
    check_all("R5 no strobe");
    le_set(1); le_set(0);
    check_all("R5 later commit");
    chk("R5 commit value", 32'(rf_ref_div), 32'h11111);

    // R6: 26 bits, only the last 22 count
    send_word({6'd0, 4'hF, 20'h2468A, 2'b01}, 26);
    le_set(1); le_set(0);
    check_all("R6 overlong");
    chk("R6 newest kept", 32'(rf_n_div), 32'h2468A);

    // R8: clocks while strobe high are ignored
    send_word({10'd0, 20'h99999, 2'b11}, 22);
    le_set(1);
    send_word({10'd0, 20'h44444, 2'b00}, 22);
    le_set(0);
    le_set(1); le_set(0);
    check_all("R8 strobe high");
    chk("R8 rf_ref untouched", 32'(rf_ref_div), 32'h11111);

    // R9: short transfer merges with leftover bits
    send_word(32'b101, 3);
    le_set(1); le_set(0);
    check_all("R9 short transfer");

    // R1: mid-run reset
    do_reset();
    check_all("R1 second reset");
    send_word(32'h3, 2);
    le_set(1); le_set(0);
    check_all("R1 shift cleared");
    chk("R1 if_n zero payload", 32'(if_n_div), 32'h0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule